// File: doc/BRIEF.md
# Multi-cycle stage-skipping processor core

This block is a small 32-bit load/store processor. Each instruction moves through a chain of sequential stages: fetch, decode with register read, execute, memory access and register write-back. The core spends exactly one clock in each stage it visits. The controller routes an instruction only through the stages that instruction needs, so short instructions finish early and the next fetch begins in the following cycle. Values travel from stage to stage in internal holding registers: the instruction word, the two operands, the ALU result and the loaded word.

The core executes four instructions: register add, signed set-less-than-immediate, load word and store word. The instruction memory and the data memory are small internal word arrays. Each has its own preload port, and these are written while the core is held in reset. Every completed instruction drives a retire record for one cycle. The record gives the instruction's address, the register write it made and the memory store it made. An external observer can follow execution from this record alone.

Top module: `mc_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter and all 32 registers to zero, puts the controller in fetch and holds `retire` low. The first instruction retired after reset is the one at byte address 0.
- R2: Fetch reads the instruction word at index `pc[IAW+1:2]` and advances the program counter by 4. Instructions retire in address order, and `retire_pc` reports the byte address of the retiring instruction.
- R3: add is encoded as bits[31:26]=0 and bits[5:0]=0x20, with rs in [25:21], rt in [20:16] and rd in [15:11]. It writes rs+rt, modulo 2^32, to rd, and it retires 4 cycles after the previous retire.
- R4: slti is encoded as opcode 0x0A, with a 16-bit immediate in [15:0] that is sign-extended. It writes 1 to rt when rs is less than the immediate as signed values, and 0 otherwise. It takes 4 cycles.
- R5: lw is encoded as opcode 0x23. It forms the address rs + sign-extended immediate and writes the data word at index `addr[DAW+1:2]` into rt. The low two address bits are ignored and higher bits wrap. It takes 5 cycles.
- R6: sw is encoded as opcode 0x2B. It uses the same address rule as R5 and writes rt into data memory. It makes no register write and takes 4 cycles. The retire record shows the full address and the stored word.
- R7: Register 0 always reads as zero. A write aimed at register 0 is dropped, and its retire record shows no register write.
- R8: Any other opcode, or opcode 0 with a function code other than 0x20, changes no register and no memory location. Such an instruction retires 2 cycles after the previous retire.
- R9: `retire` is high for exactly one cycle per instruction, in that instruction's last stage. The retire record is valid only in that cycle.
- R10: While reset is held, a preload write stores a word at the given word index of the instruction memory or the data memory, and later fetches and loads see that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_ld_we | input | 1 | Instruction memory preload write enable |
| imem_ld_idx | input | IAW | Instruction memory preload word index |
| imem_ld_word | input | 32 | Instruction memory preload data |
| dmem_ld_we | input | 1 | Data memory preload write enable |
| dmem_ld_idx | input | DAW | Data memory preload word index |
| dmem_ld_word | input | 32 | Data memory preload data |
| retire | output | 1 | One-cycle strobe for a completed instruction |
| retire_pc | output | 32 | Byte address of the retiring instruction |
| retire_rd_we | output | 1 | The retiring instruction wrote a register |
| retire_rd | output | 5 | Destination register number |
| retire_rd_val | output | 32 | Value written to the destination register |
| retire_st_we | output | 1 | The retiring instruction stored to memory |
| retire_st_addr | output | 32 | Byte address of the store |
| retire_st_data | output | 32 | Stored word |

## Verification
The assertions assume that the preload ports are used only while reset is held. A preload during execution could collide with a store or change an instruction that has already been fetched, and no property covers that case. The stimulus respects this: it writes both memories in full during reset, so every fetch and every load sees a defined word, and it raises no preload enable after reset is released. The program makes the signed compare, the add wrap-around, the address wrap and the register-0 write observable at the retire record.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
  } stage_t;

  typedef enum logic [2:0] {
    OP_NOP, OP_ADD, OP_SLTI, OP_LW, OP_SW
  } op_t;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] FN_ADD    = 6'h20;

  function automatic op_t decode_op(input logic [XLEN-1:0] w);
    case (w[31:26])
      OPC_RTYPE: return (w[5:0] == FN_ADD) ? OP_ADD : OP_NOP;
      OPC_SLTI:  return OP_SLTI;
      OPC_LW:    return OP_LW;
      OPC_SW:    return OP_SW;
      default:   return OP_NOP;
    endcase
  endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int NREG = 32,
  parameter int W    = XLEN,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // A write to a nonzero register is visible on the next cycle (R3)
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  op_t             op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] y
);

  always_comb begin
    case (op)
      OP_ADD:       y = a + b;
      OP_SLTI:      y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(imm))};
      OP_LW, OP_SW: y = a + imm;
      default:      y = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  op_t    op,
  output stage_t stage,
  output logic   retire
);

  stage_t nxt;

  always_comb begin
    case (stage)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = (op == OP_NOP) ? ST_FETCH : ST_EXEC;
      ST_EXEC:   nxt = (op == OP_LW || op == OP_SW) ? ST_MEM : ST_WB;
      ST_MEM:    nxt = (op == OP_LW) ? ST_WB : ST_FETCH;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stage <= ST_FETCH;
    else     stage <= nxt;
  end

  assign retire = (stage == ST_WB)
               || (stage == ST_MEM && op == OP_SW)
               || (stage == ST_DECODE && op == OP_NOP);

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (stage == ST_FETCH) |=> (stage == ST_DECODE));

  p_retire_then_fetch_r9: assert property (@(posedge clk) disable iff (rst)
    retire |=> (stage == ST_FETCH && !retire));

  p_exec_leads_on_r9: assert property (@(posedge clk) disable iff (rst)
    (stage == ST_EXEC) |=> (stage == ST_MEM || stage == ST_WB));

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imem_ld_we,
  input  logic [IAW-1:0]  imem_ld_idx,
  input  logic [XLEN-1:0] imem_ld_word,
  input  logic            dmem_ld_we,
  input  logic [DAW-1:0]  dmem_ld_idx,
  input  logic [XLEN-1:0] dmem_ld_word,
  output logic            retire,
  output logic [XLEN-1:0] retire_pc,
  output logic            retire_rd_we,
  output logic [RIDX-1:0] retire_rd,
  output logic [XLEN-1:0] retire_rd_val,
  output logic            retire_st_we,
  output logic [XLEN-1:0] retire_st_addr,
  output logic [XLEN-1:0] retire_st_data
);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc, cur_pc, ir, a_q, b_q, alu_q, mdr_q;
  logic [XLEN-1:0] rf_rd1, rf_rd2, alu_y, imm_sx, wb_val;
  logic [RIDX-1:0] wb_dst;
  logic            rf_we, st_we;
  op_t             op;
  stage_t          stage;

  assign op     = decode_op(ir);
  assign imm_sx = {{(XLEN-16){ir[15]}}, ir[15:0]};

  mc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .op(op), .stage(stage), .retire(retire)
  );

  mc_regfile #(.NREG(1 << RIDX), .W(XLEN)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(ir[25:21]), .ra2(ir[20:16]),
    .rd1(rf_rd1), .rd2(rf_rd2),
    .we(rf_we), .wa(wb_dst), .wd(wb_val)
  );

  mc_alu u_alu (
    .op(op), .a(a_q), .b(b_q), .imm(imm_sx), .y(alu_y)
  );

  // instruction memory: preload port plus fetch read
  always_ff @(posedge clk) begin
    if (imem_ld_we) imem[imem_ld_idx] <= imem_ld_word;
  end

  // data memory: preload port, or a store in the memory stage
  always_ff @(posedge clk) begin
    if (dmem_ld_we)  dmem[dmem_ld_idx] <= dmem_ld_word;
    else if (st_we)  dmem[alu_q[DAW+1:2]] <= b_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      cur_pc <= '0;
      ir     <= '0;
      a_q    <= '0;
      b_q    <= '0;
      alu_q  <= '0;
      mdr_q  <= '0;
    end else begin
      case (stage)
        ST_FETCH: begin
          ir     <= imem[pc[IAW+1:2]];
          cur_pc <= pc;
          pc     <= pc + XLEN'(4);
        end
        ST_DECODE: begin
          a_q <= rf_rd1;
          b_q <= rf_rd2;
        end
        ST_EXEC: alu_q <= alu_y;
        ST_MEM:  if (op == OP_LW) mdr_q <= dmem[alu_q[DAW+1:2]];
        default: ;
      endcase
    end
  end

  assign st_we  = (stage == ST_MEM) && (op == OP_SW);
  assign wb_dst = (op == OP_ADD) ? ir[15:11] : ir[20:16];
  assign wb_val = (op == OP_LW) ? mdr_q : alu_q;
  assign rf_we  = (stage == ST_WB);

  assign retire_pc      = cur_pc;
  assign retire_rd_we   = rf_we && (wb_dst != '0);
  assign retire_rd      = wb_dst;
  assign retire_rd_val  = wb_val;
  assign retire_st_we   = st_we;
  assign retire_st_addr = alu_q;
  assign retire_st_data = b_q;

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (stage == ST_FETCH) |=> (pc == $past(pc) + XLEN'(4)));

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (stage != ST_FETCH) |=> $stable(pc));

  p_store_no_regwrite_r6: assert property (@(posedge clk) disable iff (rst)
    st_we |-> !rf_we);

  p_load_uses_mem_r5: assert property (@(posedge clk) disable iff (rst)
    (stage == ST_WB && op == OP_LW) |-> ($past(stage) == ST_MEM));

endmodule

// File: tb/tb_mc_core.sv
module tb_mc_core;
  import mc_pkg::*;

  localparam int IW = 64;
  localparam int DW = 64;
  localparam int IAW = $clog2(IW);
  localparam int DAW = $clog2(DW);

  logic clk = 0;
  logic rst;
  logic imem_ld_we, dmem_ld_we;
  logic [IAW-1:0] imem_ld_idx;
  logic [DAW-1:0] dmem_ld_idx;
  logic [31:0] imem_ld_word, dmem_ld_word;
  logic retire, retire_rd_we, retire_st_we;
  logic [31:0] retire_pc, retire_rd_val, retire_st_addr, retire_st_data;
  logic [4:0] retire_rd;

  always #10 clk = ~clk;

  mc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut (
    .clk(clk), .rst(rst),
    .imem_ld_we(imem_ld_we), .imem_ld_idx(imem_ld_idx), .imem_ld_word(imem_ld_word),
    .dmem_ld_we(dmem_ld_we), .dmem_ld_idx(dmem_ld_idx), .dmem_ld_word(dmem_ld_word),
    .retire(retire), .retire_pc(retire_pc), .retire_rd_we(retire_rd_we),
    .retire_rd(retire_rd), .retire_rd_val(retire_rd_val),
    .retire_st_we(retire_st_we), .retire_st_addr(retire_st_addr),
    .retire_st_data(retire_st_data)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [3:0]  len;
    logic        rwe;
    logic [4:0]  rd;
    logic [31:0] rval;
    logic        swe;
    logic [31:0] saddr;
    logic [31:0] sdata;
    logic [3:0]  tag;
  } item_t;

  item_t exp_q[$];
  logic [31:0] m_rf [32];
  logic [31:0] m_mem [DW];
  int n_chk = 0, n_bad = 0, cnt = 0, cyc = 0;
  bit done = 0, wd_hit = 0;

  function automatic string tag_s(input logic [3:0] t);
    case (t)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] enc_add(input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] opc, input int rt,
                                        input int rs, input int imm);
    return {opc, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // driver: preload one instruction and push its expected retire record
  task automatic put(input int idx, input logic [31:0] w);
    item_t e;
    logic [31:0] imm, adr, v;
    logic [5:0] opc, fn;
    int rs, rt, rd, dst;
    opc = w[31:26]; fn = w[5:0];
    rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
    imm = {{16{w[15]}}, w[15:0]};
    e = '0; e.pc = idx * 4; dst = 0; v = '0;
    if (opc == 6'h00 && fn == 6'h20) begin
      v = m_rf[rs] + m_rf[rt]; dst = rd; e.len = 4; e.tag = (rd == 0) ? 4'd7 : 4'd3;
    end else if (opc == 6'h0A) begin
      v = ($signed(m_rf[rs]) < $signed(imm)) ? 32'd1 : 32'd0;
      dst = rt; e.len = 4; e.tag = 4'd4;
    end else if (opc == 6'h23) begin
      adr = m_rf[rs] + imm; v = m_mem[adr[DAW+1:2]];
      dst = rt; e.len = 5; e.tag = 4'd5;
    end else if (opc == 6'h2B) begin
      adr = m_rf[rs] + imm; m_mem[adr[DAW+1:2]] = m_rf[rt];
      e.swe = 1; e.saddr = adr; e.sdata = m_rf[rt]; e.len = 4; e.tag = 4'd6;
    end else begin
      e.len = 2; e.tag = 4'd8;
    end
    if (dst != 0) begin
      m_rf[dst] = v; e.rwe = 1; e.rd = 5'(dst); e.rval = v;
    end
    exp_q.push_back(e);
    imem_ld_we = 1; imem_ld_idx = IAW'(idx); imem_ld_word = w;
    @(negedge clk);
  endtask

  // monitor: pop and compare at each retire
  always @(negedge clk) begin
    item_t e;
    if (rst) cnt = 1;
    else begin
      cnt++;
      if (retire && !done) begin
        e = exp_q.pop_front();
        chk(retire_pc == e.pc, (e.pc == 0) ? "R1" : "R2", "retire_pc", retire_pc, e.pc);
        chk(cnt == int'(e.len), "R9", {tag_s(e.tag), " cycles"}, cnt, 32'(e.len));
        chk(retire_rd_we == e.rwe, tag_s(e.tag), "reg write enable", 32'(retire_rd_we), 32'(e.rwe));
        if (e.rwe) begin
          chk(retire_rd == e.rd, tag_s(e.tag), "dest reg", 32'(retire_rd), 32'(e.rd));
          chk(retire_rd_val == e.rval, tag_s(e.tag), "dest value", retire_rd_val, e.rval);
        end
        chk(retire_st_we == e.swe, tag_s(e.tag), "store enable", 32'(retire_st_we), 32'(e.swe));
        if (e.swe) begin
          chk(retire_st_addr == e.saddr, "R6", "store addr", retire_st_addr, e.saddr);
          chk(retire_st_data == e.sdata, "R6", "store data", retire_st_data, e.sdata);
        end
        cnt = 0;
        if (exp_q.size() == 0) done = 1;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst) cyc++;
    if (cyc > 3000) wd_hit = 1;
  end

  initial begin
    rst = 1; imem_ld_we = 0; dmem_ld_we = 0;
    imem_ld_idx = '0; dmem_ld_idx = '0; imem_ld_word = '0; dmem_ld_word = '0;
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    repeat (2) @(negedge clk);
    chk(retire == 1'b0, "R1", "retire in reset", 32'(retire), 32'd0);
    // R10: preload every data word
    for (int i = 0; i < DW; i++) begin
      case (i)
        0: m_mem[i] = 32'h0000_0007;
        1: m_mem[i] = 32'hFFFF_FFF0;
        2: m_mem[i] = 32'h7FFF_FFFF;
        3: m_mem[i] = 32'h1234_5678;
        8: m_mem[i] = 32'hA5A5_A5A5;
        default: m_mem[i] = 32'hD000_0000 | i;
      endcase
      dmem_ld_we = 1; dmem_ld_idx = DAW'(i); dmem_ld_word = m_mem[i];
      @(negedge clk);
    end
    dmem_ld_we = 0;
    put(0,  enc_i(6'h23, 1, 0, 0));        // R5 lw r1 = 7
    put(1,  enc_i(6'h23, 2, 0, 4));        // R5 lw r2 = -16
    put(2,  enc_add(3, 1, 2));             // R3 -9
    put(3,  enc_i(6'h0A, 4, 3, -8));       // R4 -9 < -8 -> 1
    put(4,  enc_i(6'h0A, 5, 1, 7));        // R4 equal -> 0
    put(5,  enc_i(6'h0A, 6, 2, 5));        // R4 signed negative -> 1
    put(6,  enc_i(6'h23, 7, 0, 8));        // R5 0x7FFFFFFF
    put(7,  enc_add(8, 7, 4));             // R3 wrap
    put(8,  enc_i(6'h2B, 3, 0, 20));       // R6 store
    put(9,  enc_i(6'h23, 9, 0, 20));       // R5 read back
    put(10, enc_i(6'h23, 10, 1, 28));      // R5 misaligned address
    put(11, enc_i(6'h2B, 1, 7, -4));       // R6 wrapped index
    put(12, enc_i(6'h23, 11, 0, 248));     // R5 read wrapped store
    put(13, enc_add(0, 1, 1));             // R7 write r0 dropped
    put(14, enc_add(12, 0, 1));            // R7 r0 reads zero
    put(15, 32'hFC00_0000);                // R8 unknown opcode
    put(16, 32'h0022_3022);                // R8 unknown funct
    put(17, enc_add(13, 12, 12));          // R8 state intact
    put(18, enc_i(6'h23, 14, 0, 12));      // R5
    for (int i = 19; i < IW; i++) begin
      imem_ld_we = 1; imem_ld_idx = IAW'(i); imem_ld_word = '0;
      @(negedge clk);
    end
    imem_ld_we = 0;
    rst <= 0;
    wait (done || wd_hit);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: got %0d expected %0d pending", exp_q.size(), 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule